// File: doc/BRIEF.md
# Period and Pulse-Width Capture Timer

A 16-bit down-counting timer with a reload latch, reached through a byte-wide register bus. In its plain timer mode it counts a prescaled tick. On reaching zero, the next count event reloads it from the latch and raises a one-cycle underflow request. An event-counter mode counts edges on an external pin instead of the tick.

Two measurement modes turn the block into a capture unit. Each qualifying pin edge copies the running count into a capture register, restarts the counter from the latch and raises a one-cycle edge request. Period mode responds to one edge polarity, chosen by a control bit. Continuous high/low mode responds to both polarities, so successive captures give alternate high and low widths. The external pin passes through a two-stage synchronizer before edge detection.

The 16-bit values are accessed one byte at a time. A high-byte read snapshots the low byte, so software must read the high byte first. A low-byte write only stages data and the high-byte write commits the full word, so software must write the low byte first.

Top module: `cap_timer`

## Requirements
- R1: After reset the counter and reload latch read 0xFFFF, the capture register reads 0x0000, the control register reads 0x00 and both request outputs are low.
- R2: In modes 00, 01 and 11, with the stop bit clear, each cycle with `tick_i` high lowers the counter by one.
- R3: A count event while the counter is zero reloads it from the latch and drives `unf_req_o` high for exactly one cycle.
- R4: In mode 10 the counter counts pin edges of the polarity chosen by control bit 2 (0 = rising, 1 = falling) and ignores `tick_i`.
- R5: In mode 01 a pin edge of the chosen polarity copies the count into the capture register, reloads the counter from the latch and pulses `edge_req_o` for one cycle. An edge of the other polarity does nothing.
- R6: In mode 11 both rising and falling pin edges perform the capture, reload and request of R5.
- R7: A change on `pin_i` takes effect at the third rising clock edge after it. Two edges after the change, no request has yet appeared.
- R8: Bus address 0 stages a low byte without changing the latch. A write to address 1 commits {written byte, staged byte} to the latch.
- R9: A read of address 1 returns the high byte and snapshots the low byte. A later read of address 0 returns that snapshot, even if the counter has moved since.
- R10: Addresses 0/1 read the counter in modes 00 and 10 and the capture register in modes 01 and 11. Address 2 reads back the control byte {stop[3], edge select[2], mode[1:0]}.
- R11: While the stop bit (control bit 3) is set, ticks and pin edges change neither the counter nor the capture register and raise no request.
- R12: A latch commit while running changes neither the counter nor the capture register.
- R13: A latch commit while the stop bit is set also loads the committed word into the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Prescaled internal count enable |
| pin_i | input | 1 | External counter pin, asynchronous |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe (used for the byte snapshot) |
| addr_i | input | 2 | Register address: 0 low byte, 1 high byte, 2 control |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, combinational from the address |
| unf_req_o | output | 1 | One-cycle underflow request |
| edge_req_o | output | 1 | One-cycle capture (pin edge) request |

## Verification
The hardest case to reach from the ports is a capture of a count that is known in advance. The counter would otherwise run freely while the pin edge crosses the synchronizer. The stimulus therefore holds `tick_i` low except for counted single-cycle pulses, so the counter stands still at a known value while an edge is in flight. Each edge then gives an exact capture value and an exact reload value. The same quiet-counter setup lets the bench watch `edge_req_o` two and three clock edges after a pin change, which pins down the synchronizer latency.

// File: rtl/cap_tmr_pkg.sv
`timescale 1ns/1ps
package cap_tmr_pkg;

  typedef enum logic [1:0] {
    MODE_TIMER  = 2'b00,
    MODE_PERIOD = 2'b01,
    MODE_EVENT  = 2'b10,
    MODE_HILO   = 2'b11
  } mode_e;

  typedef struct packed {
    logic  stop;
    logic  edge_fall;
    mode_e mode;
  } ctrl_t;

  localparam logic [1:0] ADDR_LO   = 2'd0;
  localparam logic [1:0] ADDR_HI   = 2'd1;
  localparam logic [1:0] ADDR_CTRL = 2'd2;

endpackage

// File: rtl/cap_tmr_sync.sv
`timescale 1ns/1ps
module cap_tmr_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  output logic rise_o,
  output logic fall_o
);

  logic [STAGES-1:0] stage_q;
  logic              prev_q;
  logic              level;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      logic stage_d;
      if (g == 0) begin : g_first
        always_comb stage_d = pin_i;
      end else begin : g_next
        always_comb stage_d = stage_q[g-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[g] <= 1'b0;
        else        stage_q[g] <= stage_d;
      end
    end
  endgenerate

  assign level = stage_q[STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= level;
  end

  always_comb begin
    rise_o = level & ~prev_q;
    fall_o = ~level & prev_q;
  end

  // R7: a detected edge is a single-cycle event
  a_r7_edge_single: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_o || fall_o) |=> !(rise_o || fall_o));

endmodule

// File: rtl/cap_tmr_regs.sv
`timescale 1ns/1ps
module cap_tmr_regs
  import cap_tmr_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en_i,
  input  logic             rd_en_i,
  input  logic [1:0]       addr_i,
  input  logic [7:0]       wdata_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] cap_i,
  output ctrl_t            ctrl_o,
  output logic [CNT_W-1:0] latch_o,
  output logic             load_o,
  output logic [CNT_W-1:0] load_val_o,
  output logic [7:0]       rdata_o
);

  localparam int HI_W = CNT_W - 8;

  ctrl_t            ctrl_q, ctrl_d;
  logic [7:0]       stage_q, stage_d;
  logic [7:0]       hold_q, hold_d;
  logic [CNT_W-1:0] latch_q, latch_d;
  logic [CNT_W-1:0] src;
  logic             commit;
  logic             meas;

  always_comb begin
    meas   = (ctrl_q.mode == MODE_PERIOD) || (ctrl_q.mode == MODE_HILO);
    src    = meas ? cap_i : cnt_i;
    commit = wr_en_i && (addr_i == ADDR_HI);

    load_val_o = {wdata_i[HI_W-1:0], stage_q};
    load_o     = commit && ctrl_q.stop;

    ctrl_d  = ctrl_q;
    stage_d = stage_q;
    latch_d = latch_q;
    hold_d  = hold_q;
    if (wr_en_i && (addr_i == ADDR_CTRL)) ctrl_d  = ctrl_t'(wdata_i[3:0]);
    if (wr_en_i && (addr_i == ADDR_LO))   stage_d = wdata_i;
    if (commit)                           latch_d = load_val_o;
    if (rd_en_i && (addr_i == ADDR_HI))   hold_d  = src[7:0];

    case (addr_i)
      ADDR_LO:   rdata_o = hold_q;
      ADDR_HI:   rdata_o = 8'(src[CNT_W-1:8]);
      ADDR_CTRL: rdata_o = {4'b0000, ctrl_q};
      default:   rdata_o = 8'h00;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      stage_q <= '0;
      hold_q  <= '0;
      latch_q <= '1;
    end else begin
      ctrl_q  <= ctrl_d;
      stage_q <= stage_d;
      hold_q  <= hold_d;
      latch_q <= latch_d;
    end
  end

  assign ctrl_o  = ctrl_q;
  assign latch_o = latch_q;

  // R8: a staged low byte leaves the reload latch alone
  a_r8_low_stage_only: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && addr_i == ADDR_LO) |=> $stable(latch_q));

  // R9: the low-byte read returns what the high-byte read saw
  a_r9_snapshot: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en_i && addr_i == ADDR_HI) |=> hold_q == $past(src[7:0]));

endmodule

// File: rtl/cap_tmr_core.sv
`timescale 1ns/1ps
module cap_tmr_core
  import cap_tmr_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             rise_i,
  input  logic             fall_i,
  input  ctrl_t            ctrl_i,
  input  logic [CNT_W-1:0] latch_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] cap_o,
  output logic             unf_o,
  output logic             edge_o
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] cap_q, cap_d;
  logic             unf_q, unf_d;
  logic             edg_q, edg_d;
  logic             sel_edge, cnt_ev, cap_ev;

  always_comb begin
    sel_edge = ctrl_i.edge_fall ? fall_i : rise_i;
    cnt_ev   = (ctrl_i.mode == MODE_EVENT) ? sel_edge : tick_i;
    case (ctrl_i.mode)
      MODE_PERIOD: cap_ev = sel_edge;
      MODE_HILO:   cap_ev = rise_i | fall_i;
      default:     cap_ev = 1'b0;
    endcase

    cnt_d = cnt_q;
    cap_d = cap_q;
    unf_d = 1'b0;
    edg_d = 1'b0;
    if (load_i) begin
      cnt_d = load_val_i;
    end else if (!ctrl_i.stop) begin
      if (cap_ev) begin
        cap_d = cnt_q;
        cnt_d = latch_i;
        edg_d = 1'b1;
      end else if (cnt_ev) begin
        if (cnt_q == '0) begin
          cnt_d = latch_i;
          unf_d = 1'b1;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '1;
      cap_q <= '0;
      unf_q <= 1'b0;
      edg_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      cap_q <= cap_d;
      unf_q <= unf_d;
      edg_q <= edg_d;
    end
  end

  assign cnt_o  = cnt_q;
  assign cap_o  = cap_q;
  assign unf_o  = unf_q;
  assign edge_o = edg_q;

  // R2: a plain count event lowers the counter by one
  a_r2_decrement: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_i.stop && !load_i && tick_i && ctrl_i.mode != MODE_EVENT && !cap_ev && cnt_q != '0)
    |=> cnt_q == CNT_W'($past(cnt_q) - 1'b1));

  // R3: an underflow request comes with the reload value
  a_r3_underflow_reload: assert property (@(posedge clk) disable iff (!rst_n)
    unf_q |-> cnt_q == $past(latch_i));

  // R5: a capture holds the count seen just before it
  a_r5_capture_value: assert property (@(posedge clk) disable iff (!rst_n)
    edg_q |-> cap_q == $past(cnt_q));

  // R12: the capture register only moves with a capture request
  a_r12_capture_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !edg_q |-> $stable(cap_q));

  // R11: stop freezes counter and capture
  a_r11_stop_freezes: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_i.stop && !load_i) |=> ($stable(cnt_q) && $stable(cap_q)));

  // R6: at most one request per cycle
  a_r6_one_request: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({unf_q, edg_q}));

endmodule

// File: rtl/cap_timer.sv
`timescale 1ns/1ps
module cap_timer
  import cap_tmr_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_i,
  input  logic       pin_i,
  input  logic       wr_en_i,
  input  logic       rd_en_i,
  input  logic [1:0] addr_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] rdata_o,
  output logic       unf_req_o,
  output logic       edge_req_o
);

  logic [1:0]       rst_pipe_q;
  logic             rst_sync_n;
  logic             rise, fall;
  ctrl_t            ctrl;
  logic [CNT_W-1:0] latch_val, load_val, cnt_val, cap_val;
  logic             load_stb;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  cap_tmr_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .pin_i  (pin_i),
    .rise_o (rise),
    .fall_o (fall)
  );

  cap_tmr_regs #(.CNT_W(CNT_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .wr_en_i    (wr_en_i),
    .rd_en_i    (rd_en_i),
    .addr_i     (addr_i),
    .wdata_i    (wdata_i),
    .cnt_i      (cnt_val),
    .cap_i      (cap_val),
    .ctrl_o     (ctrl),
    .latch_o    (latch_val),
    .load_o     (load_stb),
    .load_val_o (load_val),
    .rdata_o    (rdata_o)
  );

  cap_tmr_core #(.CNT_W(CNT_W)) u_core (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .tick_i     (tick_i),
    .rise_i     (rise),
    .fall_i     (fall),
    .ctrl_i     (ctrl),
    .latch_i    (latch_val),
    .load_i     (load_stb),
    .load_val_i (load_val),
    .cnt_o      (cnt_val),
    .cap_o      (cap_val),
    .unf_o      (unf_req_o),
    .edge_o     (edge_req_o)
  );

  // R13: a commit while stopped lands in the counter
  a_r13_stopped_load: assert property (@(posedge clk) disable iff (!rst_sync_n)
    load_stb |=> cnt_val == $past(load_val));

endmodule

// File: tb/cap_timer_test.sv
`timescale 1ns/1ps
module cap_timer_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_i = 1'b0;
  logic       pin_i = 1'b0;
  logic       wr_en_i = 1'b0;
  logic       rd_en_i = 1'b0;
  logic [1:0] addr_i = 2'd0;
  logic [7:0] wdata_i = 8'h00;
  logic [7:0] rdata_o;
  logic       unf_req_o, edge_req_o;

  int n_chk = 0;
  int n_fail = 0;
  int unf_cnt = 0;
  int edge_cnt = 0;

  logic [15:0] exp_q[$];
  string       tag_q[$];
  logic [15:0] obs_q[$];

  always #4 clk = ~clk;

  cap_timer uut (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .pin_i(pin_i),
    .wr_en_i(wr_en_i), .rd_en_i(rd_en_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o),
    .unf_req_o(unf_req_o), .edge_req_o(edge_req_o)
  );

  always @(negedge clk) begin
    if (rst_n && unf_req_o)  unf_cnt++;
    if (rst_n && edge_req_o) edge_cnt++;
  end

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // scoreboard monitor
  initial begin
    forever begin
      @(negedge clk);
      #2;
      while (obs_q.size() > 0 && exp_q.size() > 0) begin
        chk(tag_q.pop_front(), obs_q.pop_front(), exp_q.pop_front());
      end
    end
  end

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    addr_i = a; wdata_i = d; wr_en_i = 1'b1;
    @(negedge clk);
    wr_en_i = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick_i = 1'b1;
      @(negedge clk); tick_i = 1'b0;
    end
  endtask

  task automatic read16(input int between);
    logic [7:0] hi, lo;
    @(negedge clk);
    addr_i = 2'd1; rd_en_i = 1'b1;
    #1 hi = rdata_o;
    @(negedge clk);
    rd_en_i = 1'b0;
    ticks(between);
    addr_i = 2'd0;
    #1 lo = rdata_o;
    obs_q.push_back({hi, lo});
  endtask

  task automatic expect_read(input string tag, input logic [15:0] exp, input int between);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    read16(between);
  endtask

  task automatic pin_to(input logic v, input logic exp_req, input string tag);
    @(negedge clk);
    pin_i = v;
    @(negedge clk);
    @(negedge clk);
    chk({tag, " R7 no request after two edges"}, {15'd0, edge_req_o}, 16'd0);
    @(negedge clk);
    chk({tag, " request on third edge"}, {15'd0, edge_req_o}, {15'd0, exp_req});
    repeat (2) @(negedge clk);
  endtask

  task automatic load_word(input logic [15:0] w);
    wr(2'd2, 8'h08);
    wr(2'd0, w[7:0]);
    wr(2'd1, w[15:8]);
  endtask

  initial begin
    #(8 * 100000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk("R1 unf low", {15'd0, unf_req_o}, 16'd0);
    chk("R1 edge low", {15'd0, edge_req_o}, 16'd0);
    addr_i = 2'd2; #1;
    chk("R1 control zero", {8'd0, rdata_o}, 16'h0000);
    expect_read("R1 counter all ones", 16'hFFFF, 0);
    wr(2'd2, 8'h01);
    expect_read("R1 capture zero", 16'h0000, 0);

    // R8 / R13 staged writes
    wr(2'd2, 8'h08);
    wr(2'd0, 8'h34);
    expect_read("R8 low write alone", 16'hFFFF, 0);
    wr(2'd1, 8'h12);
    expect_read("R13 stopped commit loads", 16'h1234, 0);

    // R2 counting
    wr(2'd2, 8'h00);
    ticks(5);
    expect_read("R2 five ticks", 16'h122F, 0);
    // R9 snapshot across a tick
    expect_read("R9 low byte snapshot", 16'h122F, 1);
    expect_read("R9 counter moved", 16'h122E, 0);

    // R11 stop
    wr(2'd2, 8'h08);
    ticks(4);
    expect_read("R11 stopped ticks", 16'h122E, 0);

    // R3 underflow
    load_word(16'h0002);
    wr(2'd2, 8'h00);
    ticks(2);
    expect_read("R3 reached zero", 16'h0000, 0);
    repeat (2) @(negedge clk);
    chk("R3 no early underflow", 16'(unf_cnt), 16'd0);
    ticks(1);
    repeat (2) @(negedge clk);
    chk("R3 single underflow pulse", 16'(unf_cnt), 16'd1);
    expect_read("R3 reload", 16'h0002, 0);

    // R4 event counter
    load_word(16'h0010);
    wr(2'd2, 8'h02);
    ticks(3);
    expect_read("R4 tick ignored", 16'h0010, 0);
    pin_to(1'b1, 1'b0, "R4 rise");
    pin_to(1'b0, 1'b0, "R4 fall");
    pin_to(1'b1, 1'b0, "R4 rise");
    pin_to(1'b0, 1'b0, "R4 fall");
    expect_read("R4 two rising edges", 16'h000E, 0);
    wr(2'd2, 8'h06);
    pin_to(1'b1, 1'b0, "R4 rise");
    pin_to(1'b0, 1'b0, "R4 fall");
    expect_read("R4 one falling edge", 16'h000D, 0);

    // R5 period mode
    load_word(16'h0100);
    wr(2'd2, 8'h01);
    ticks(6);
    pin_to(1'b1, 1'b1, "R5 rising capture");
    expect_read("R5 capture value", 16'h00FA, 0);
    pin_to(1'b0, 1'b0, "R5 other edge ignored");
    wr(2'd2, 8'h00);
    expect_read("R5 counter reloaded", 16'h0100, 0);

    // R12 latch commit while running
    wr(2'd2, 8'h01);
    wr(2'd0, 8'h00);
    wr(2'd1, 8'h02);
    expect_read("R12 capture untouched", 16'h00FA, 0);
    wr(2'd2, 8'h00);
    expect_read("R12 counter not loaded", 16'h0100, 0);

    // R6 both edges
    wr(2'd2, 8'h03);
    ticks(3);
    pin_to(1'b1, 1'b1, "R6 rise");
    expect_read("R6 high/low first capture", 16'h00FD, 0);
    ticks(7);
    pin_to(1'b0, 1'b1, "R6 fall");
    expect_read("R6 high/low second capture", 16'h01F9, 0);
    wr(2'd2, 8'h00);
    expect_read("R6 counter reloaded", 16'h0200, 0);
    chk("R6 capture request total", 16'(edge_cnt), 16'd3);

    // R11 stop in measurement, R10 control readback
    wr(2'd2, 8'h0B);
    @(negedge clk);
    addr_i = 2'd2; #1;
    chk("R10 control readback", {8'd0, rdata_o}, 16'h000B);
    pin_to(1'b1, 1'b0, "R11 stopped edge");
    ticks(2);
    expect_read("R11 capture frozen", 16'h01F9, 0);
    wr(2'd2, 8'h08);
    expect_read("R11 counter frozen", 16'h0200, 0);
    chk("R11 no extra request", 16'(edge_cnt), 16'd3);

    repeat (4) @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule